// File: doc/BRIEF.md
# Segmented Little-Endian Data Access Sequencer

This block sits on the data side of a 16-bit processor. It turns one load or store request into the byte-lane bus cycles of a 16-bit external data bus with a 20-bit byte address. A request carries a 16-bit segment, a 16-bit offset, a byte-or-word size, a direction and, for stores, the write data. The block forms the physical address by shifting the segment left four bits and adding the offset, modulo 2^20. It then runs one bus cycle, or two when a word starts at an odd address.

Word data is little-endian: the least significant byte belongs at the physical address and the most significant byte at the following address. The block steers each byte onto the lane that its address selects. Even addresses use the low lane and odd addresses use the high lane. On a load it rebuilds the word from the lanes and presents it with a one-clock completion pulse. A new request is taken only while the idle indicator is high. Each bus cycle waits for a ready input.

Top module: `seg_mem_seq`

## Requirements
- R1: A request accepted while `req_rdy` is high drives `bus_req` high on the next clock, with `bus_addr` = ((`req_seg` << 4) + `req_off`) mod 2^20.
- R2: A byte access uses one bus cycle. At an even address `bus_be` = 2'b01 and the byte is on `bus_wdata[7:0]`. At an odd address `bus_be` = 2'b10 and the byte is on `bus_wdata[15:8]`. A byte load returns the addressed lane byte in `rdata[7:0]` with `rdata[15:8]` = 0.
- R3: A word access at an even address uses one bus cycle with `bus_be` = 2'b11, the low data byte on `bus_wdata[7:0]` and the high byte on `bus_wdata[15:8]`.
- R4: A word access at an odd address P uses two bus cycles. The first is at P with `bus_be` = 2'b10 and the low data byte on `bus_wdata[15:8]`. The second is at (P+1) mod 2^20 with `bus_be` = 2'b01 and the high data byte on `bus_wdata[7:0]`.
- R5: A word load returns `rdata` = {byte at address P+1, byte at address P}, where the byte at an even address is taken from lane bits [7:0] and the byte at an odd address from lane bits [15:8].
- R6: While `bus_req` is high and `bus_ready` is low, `bus_addr`, `bus_be`, `bus_we` and `bus_wdata` hold their values.
- R7: `done` is high for exactly one clock, the clock after `bus_ready` is sampled high in the final bus cycle. For a load, `rdata` is valid then and does not change until the next request is accepted.
- R8: `req_rdy` is high only while no bus cycle is in progress. A `req_valid` pulse while `req_rdy` is low is ignored and does not change the current cycle or start another one.
- R9: During and right after reset, `req_rdy` = 1, `bus_req` = 0, `bus_be` = 0 and `done` = 0.
- R10: Whenever `bus_req` is low, `bus_be` = 0 and `bus_we` = 0. `bus_we` equals the request's direction during its bus cycles (1 = store).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_rdy | output | 1 | Unit idle, request will be taken |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within segment |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 16 | Store data (byte uses bits 7:0) |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Byte address of the cycle |
| bus_be | output | 2 | Lane strobes: bit 0 even lane, bit 1 odd lane |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Lane read data |
| bus_ready | input | 1 | Completes the current bus cycle |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled load data |

## Verification
The assertions assume that request fields only matter in the clock where `req_valid` meets `req_rdy`, and that `bus_ready` is raised only while `bus_req` is high. The bench keeps to this. It raises `bus_ready` only inside a cycle and lowers `req_valid` in the same step in which it gives the final ready, so no request is pending when the unit returns to idle. It also pokes `req_valid` with altered fields only during wait states. A bus model with a computed byte pattern supplies the read lanes. The sweep covers segments and offsets that include the 2^20 wrap, both sizes, both directions and zero to two wait states.

// File: rtl/seg_mem_pkg.sv
// Package: shared types for the segmented data access sequencer.
// Assumes: used by every module of the block; holds no logic.
package seg_mem_pkg;

    // Sequencer phase: idle, first bus cycle, second (split-word) bus cycle.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_e;

endpackage

// File: rtl/smu_addr_gen.sv
// Module: smu_addr_gen
// Forms the physical address from segment and offset, and the address that
// follows a latched base address. Both sums wrap modulo 2^PA_W.
// Assumes: PA_W >= SEG_W + SEG_SHIFT is not required; excess bits drop.
module smu_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 20,
    parameter int SEG_SHIFT = 4
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [PA_W-1:0]  base_pa,
    output logic [PA_W-1:0]  phys_pa,
    output logic [PA_W-1:0]  next_pa
);

    // Shifted segment plus offset, truncated to the address width.
    always_comb begin
        phys_pa = (PA_W'(seg) << SEG_SHIFT) + PA_W'(off);
    end

    // Address of the byte after the base, for the second half of a split word.
    always_comb begin
        next_pa = base_pa + PA_W'(1);
    end

endmodule

// File: rtl/smu_lane_plan.sv
// Module: smu_lane_plan
// Chooses lane strobes and steers write bytes for the current bus cycle.
// A full-width cycle is a word at an even address. Every other cycle moves
// one byte on lane (addr_lsb XOR second).
// Assumes: a 16-bit bus of two lanes; 'second' is only set for split words.
module smu_lane_plan #(
    parameter int BYTE_W = 8
) (
    input  logic                active,
    input  logic                second,
    input  logic                word,
    input  logic                addr_lsb,
    input  logic [2*BYTE_W-1:0] wdata,
    output logic [1:0]          be,
    output logic [2*BYTE_W-1:0] lane_wdata,
    output logic                full,
    output logic                lane_sel
);

    localparam int LANES = 2;

    logic [BYTE_W-1:0] src_byte;

    // Width and single-lane selection for this cycle.
    always_comb begin
        full     = word & ~addr_lsb;
        lane_sel = addr_lsb ^ second;
        src_byte = second ? wdata[BYTE_W +: BYTE_W] : wdata[0 +: BYTE_W];
    end

    // Per-lane strobe and data steering.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            be[l] = active & (full | (lane_sel == 1'(l)));
            if (!active) begin
                lane_wdata[l*BYTE_W +: BYTE_W] = '0;
            end else if (full) begin
                lane_wdata[l*BYTE_W +: BYTE_W] = wdata[l*BYTE_W +: BYTE_W];
            end else if (lane_sel == 1'(l)) begin
                lane_wdata[l*BYTE_W +: BYTE_W] = src_byte;
            end else begin
                lane_wdata[l*BYTE_W +: BYTE_W] = '0;
            end
        end
    end

endmodule

// File: rtl/smu_rd_merge.sv
// Module: smu_rd_merge
// Builds load data in little-endian order from the lanes. A full cycle
// takes both lanes. A first single-lane cycle fills the low byte and clears
// the high byte. A second cycle fills the high byte.
// Assumes: 'capture' is raised only on completed load cycles.
module smu_rd_merge #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic                full,
    input  logic                second,
    input  logic                lane_sel,
    input  logic [2*BYTE_W-1:0] bus_rdata,
    output logic [2*BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] lane_byte;

    // Byte from the lane used by a single-lane cycle.
    always_comb begin
        lane_byte = lane_sel ? bus_rdata[BYTE_W +: BYTE_W] : bus_rdata[0 +: BYTE_W];
    end

    // Result register, updated only on a completed load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            if (full) begin
                rdata <= bus_rdata;
            end else if (!second) begin
                rdata <= {{BYTE_W{1'b0}}, lane_byte};
            end else begin
                rdata[BYTE_W +: BYTE_W] <= lane_byte;
            end
        end
    end

endmodule

// File: rtl/smu_seq_ctrl.sv
// Module: smu_seq_ctrl
// Phase sequencer. It latches a request while idle, then advances one bus
// cycle per sampled ready. It inserts a second cycle for a word at an odd
// address and pulses done once after the final cycle.
// Assumes: request fields are valid in the clock req_valid is taken.
module smu_seq_ctrl #(
    parameter int PA_W   = 20,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_word,
    input  logic                          req_write,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [PA_W-1:0]               req_pa,
    input  logic                          bus_ready,
    output seg_mem_pkg::seq_state_e       state,
    output logic [PA_W-1:0]               base_pa,
    output logic                          word_q,
    output logic                          write_q,
    output logic [DATA_W-1:0]             wdata_q,
    output logic                          capture,
    output logic                          done
);

    import seg_mem_pkg::*;

    logic accept;
    logic split;
    logic last;

    // Control decodes for the current phase.
    always_comb begin
        accept  = (state == SEQ_IDLE) & req_valid;
        split   = word_q & base_pa[0];
        capture = (state != SEQ_IDLE) & bus_ready;
        last    = (state == SEQ_SECOND) | ~split;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE:   if (req_valid) state <= SEQ_FIRST;
                SEQ_FIRST:  if (bus_ready) state <= split ? SEQ_SECOND : SEQ_IDLE;
                SEQ_SECOND: if (bus_ready) state <= SEQ_IDLE;
                default:    state <= SEQ_IDLE;
            endcase
        end
    end

    // Request capture while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_pa <= '0;
            word_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            base_pa <= req_pa;
            word_q  <= req_word;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // One-clock completion pulse after the final ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= capture & last;
        end
    end

endmodule

// File: rtl/seg_mem_seq.sv
// Module: seg_mem_seq (top)
// Data-side access sequencer. It turns segment:offset byte/word requests
// into one or two byte-lane cycles on a 16-bit bus with a 20-bit address,
// in little-endian byte order.
// Assumes: bus_ready is driven only while bus_req is high; two lanes.
module seg_mem_seq #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 20,
    parameter int SEG_SHIFT = 4,
    parameter int BYTE_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_rdy,
    input  logic [SEG_W-1:0]    req_seg,
    input  logic [OFF_W-1:0]    req_off,
    input  logic                req_word,
    input  logic                req_write,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic                bus_req,
    output logic                bus_we,
    output logic [PA_W-1:0]     bus_addr,
    output logic [1:0]          bus_be,
    output logic [2*BYTE_W-1:0] bus_wdata,
    input  logic [2*BYTE_W-1:0] bus_rdata,
    input  logic                bus_ready,
    output logic                done,
    output logic [2*BYTE_W-1:0] rdata
);

    import seg_mem_pkg::*;

    localparam int DATA_W = 2 * BYTE_W;

    seq_state_e        state;
    logic [PA_W-1:0]   phys_pa;
    logic [PA_W-1:0]   next_pa;
    logic [PA_W-1:0]   base_pa;
    logic              word_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              capture;
    logic              second;
    logic              full;
    logic              lane_sel;
    logic              rd_capture;

    smu_addr_gen #(
        .SEG_W     (SEG_W),
        .OFF_W     (OFF_W),
        .PA_W      (PA_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_addr (
        .seg     (req_seg),
        .off     (req_off),
        .base_pa (base_pa),
        .phys_pa (phys_pa),
        .next_pa (next_pa)
    );

    smu_seq_ctrl #(
        .PA_W   (PA_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_word  (req_word),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_pa    (phys_pa),
        .bus_ready (bus_ready),
        .state     (state),
        .base_pa   (base_pa),
        .word_q    (word_q),
        .write_q   (write_q),
        .wdata_q   (wdata_q),
        .capture   (capture),
        .done      (done)
    );

    // Bus-side decodes of the phase.
    always_comb begin
        second     = (state == SEQ_SECOND);
        bus_req    = (state != SEQ_IDLE);
        req_rdy    = (state == SEQ_IDLE);
        bus_we     = bus_req & write_q;
        bus_addr   = second ? next_pa : base_pa;
        rd_capture = capture & ~write_q;
    end

    smu_lane_plan #(
        .BYTE_W (BYTE_W)
    ) u_lane (
        .active     (bus_req),
        .second     (second),
        .word       (word_q),
        .addr_lsb   (base_pa[0]),
        .wdata      (wdata_q),
        .be         (bus_be),
        .lane_wdata (bus_wdata),
        .full       (full),
        .lane_sel   (lane_sel)
    );

    smu_rd_merge #(
        .BYTE_W (BYTE_W)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (rd_capture),
        .full      (full),
        .second    (second),
        .lane_sel  (lane_sel),
        .bus_rdata (bus_rdata),
        .rdata     (rdata)
    );

endmodule

// File: rtl/seg_mem_seq_chk.sv
// Module: seg_mem_seq_chk
// Port-level protocol checks for seg_mem_seq, attached by bind.
// Assumes: bus_ready is high only inside a bus cycle.
module seg_mem_seq_chk #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int PA_W      = 20,
    parameter int SEG_SHIFT = 4,
    parameter int DATA_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_rdy,
    input logic [SEG_W-1:0]  req_seg,
    input logic [OFF_W-1:0]  req_off,
    input logic              bus_req,
    input logic              bus_we,
    input logic [PA_W-1:0]   bus_addr,
    input logic [1:0]        bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              done
);

    // Accepted request drives its physical address next clock.
    assert_addr_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rdy) |=> (bus_req &&
            bus_addr == ((PA_W'($past(req_seg)) << SEG_SHIFT) + PA_W'($past(req_off)))));

    // Every bus cycle strobes at least one lane.
    assert_lane_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_be != 2'b00));

    // Cycle signals hold while waiting for ready.
    assert_hold_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)
            && $stable(bus_we) && $stable(bus_wdata)));

    // Completion is a single-clock pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion only follows a sampled ready inside a cycle.
    assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_ready));

    // Idle indicator never overlaps a bus cycle.
    assert_rdy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_rdy |-> !bus_req);

    // No strobes or write outside a bus cycle.
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_be == 2'b00 && !bus_we));

endmodule

bind seg_mem_seq seg_mem_seq_chk #(
    .SEG_W     (SEG_W),
    .OFF_W     (OFF_W),
    .PA_W      (PA_W),
    .SEG_SHIFT (SEG_SHIFT),
    .DATA_W    (2*BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_rdy   (req_rdy),
    .req_seg   (req_seg),
    .req_off   (req_off),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .done      (done)
);

// File: tb/seg_mem_seq_tb.sv
`timescale 1ns/1ps
module seg_mem_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_rdy;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        bus_req;
    logic        bus_we;
    logic [19:0] bus_addr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ready = 1'b0;
    logic        done;
    logic [15:0] rdata;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    seg_mem_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_rdy   (req_rdy),
        .req_seg   (req_seg),
        .req_off   (req_off),
        .req_word  (req_word),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .done      (done),
        .rdata     (rdata)
    );

    // Memory content as a function of the byte address.
    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A ^ {7'd0, a[12]};
    endfunction

    // Bus model: even-address byte on the low lane, odd on the high lane.
    always_comb begin
        bus_rdata = {pat({bus_addr[19:1], 1'b1}), pat({bus_addr[19:1], 1'b0})};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [15:0] seg, input logic [15:0] off,
                           input bit word, input bit wr, input logic [15:0] wd,
                           input int waits, input bit poke);
        logic [19:0] pa;
        logic [15:0] exp_rd;
        int ncyc;
        pa = (20'(seg) << 4) + 20'(off);
        ncyc = (word && pa[0]) ? 2 : 1;
        exp_rd = word ? {pat(pa + 20'd1), pat(pa)} : {8'h00, pat(pa)};
        @(negedge clk);
        chk(req_rdy == 1'b1, "R8", "idle before request", 32'(req_rdy), 1);
        req_seg = seg; req_off = off; req_word = word;
        req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            logic [19:0] a_e;
            logic [1:0]  be_e;
            logic [15:0] wd_e;
            string tag;
            a_e = (c == 0) ? pa : pa + 20'd1;
            if (word && !pa[0]) begin
                tag = "R3"; be_e = 2'b11; wd_e = wd;
            end else if (word) begin
                tag = "R4";
                be_e = (c == 0) ? 2'b10 : 2'b01;
                wd_e = (c == 0) ? {wd[7:0], 8'h00} : {8'h00, wd[15:8]};
            end else begin
                tag = "R2";
                be_e = pa[0] ? 2'b10 : 2'b01;
                wd_e = pa[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
            end
            chk(bus_req == 1'b1, "R1", "bus cycle active", 32'(bus_req), 1);
            chk(bus_addr == a_e, (c == 0) ? "R1" : "R4", "address", 32'(bus_addr), 32'(a_e));
            chk(bus_be == be_e, tag, "strobes", 32'(bus_be), 32'(be_e));
            chk(bus_we == wr, "R10", "write flag", 32'(bus_we), 32'(wr));
            if (wr) chk(bus_wdata == wd_e, tag, "lane data", 32'(bus_wdata), 32'(wd_e));
            chk(req_rdy == 1'b0, "R8", "busy", 32'(req_rdy), 0);
            for (int w = 0; w < waits; w++) begin
                if (poke) begin
                    req_valid = 1'b1; req_seg = ~seg; req_off = ~off;
                    req_word = ~word; req_write = ~wr;
                end
                @(negedge clk);
                chk(bus_addr == a_e && bus_be == be_e && bus_we == wr,
                    "R6", "hold during wait", 32'(bus_addr), 32'(a_e));
                if (wr) chk(bus_wdata == wd_e, "R6", "data hold", 32'(bus_wdata), 32'(wd_e));
                chk(done == 1'b0, "R7", "no done while waiting", 32'(done), 0);
            end
            req_valid = 1'b0;
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0;
            if (c < ncyc - 1) chk(done == 1'b0, "R7", "no done between halves", 32'(done), 0);
        end
        chk(done == 1'b1, "R7", "done after final ready", 32'(done), 1);
        if (!wr) chk(rdata == exp_rd, word ? "R5" : "R2", "load data", 32'(rdata), 32'(exp_rd));
        @(negedge clk);
        chk(done == 1'b0, "R7", "done one clock", 32'(done), 0);
        chk(bus_req == 1'b0, "R8", "busy request ignored", 32'(bus_req), 0);
        chk(bus_be == 2'b00 && bus_we == 1'b0, "R10", "quiet when idle", 32'({bus_we, bus_be}), 0);
        if (!wr) chk(rdata == exp_rd, "R7", "load data held", 32'(rdata), 32'(exp_rd));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [15:0] segs [4];
        logic [15:0] offs [7];
        int n;
        segs = '{16'h0000, 16'h0001, 16'h345B, 16'hFFFF};
        offs = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h7FFF, 16'hFFFE, 16'hFFFF};
        repeat (3) @(negedge clk);
        // R9: state during reset
        chk(req_rdy == 1'b1 && bus_req == 1'b0, "R9", "reset idle", 32'({req_rdy, bus_req}), 2);
        chk(bus_be == 2'b00 && done == 1'b0, "R9", "reset quiet", 32'({done, bus_be}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_rdy == 1'b1 && bus_req == 1'b0 && bus_be == 2'b00 && done == 1'b0,
            "R9", "after reset", 32'({req_rdy, bus_req, bus_be, done}), 32'h10);
        n = 0;
        foreach (segs[s]) begin
            foreach (offs[o]) begin
                for (int k = 0; k < 4; k++) begin
                    run_txn(segs[s], offs[o], k[0], k[1],
                            16'hA55A ^ 16'(n * 16'h1357), n % 3, (n % 2) == 1);
                    n++;
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule